// File: doc/BRIEF.md
# MDIO Management Bus Master

This block is a register-mapped master for the two-wire management bus that reaches PHY registers. Software programs a target PHY and register number, selects an MDC rate through a coded divider field, and then launches frames. A write frame starts the moment the write-data register is written. A read frame starts when the read bit of the command register goes from 0 to 1. Software polls the busy flag and then collects the 16-bit result from the read-data register. After each read it clears the read bit again.

MDC is produced by dividing the system clock and idles low between frames. The bidirectional data line is driven through separate output, output-enable and input pins. Every frame is 64 bits long: 32 preamble ones, the start pattern `01`, an opcode (`10` read, `01` write), the 5-bit PHY address MSB first, the 5-bit register number MSB first, a two-bit turnaround, and 16 data bits MSB first. The output changes only on falling MDC edges. Read data is sampled on rising MDC edges.

Top module: `mdm_master`

## Requirements
- R1: After reset every register reads 0, MDC is low, the output enable is low and the busy flag is 0.
- R2: Registers sit at word index 0 (config), 1 (command), 2 (address), 3 (write data), 4 (read data) and 5 (status). The address register holds the PHY address in bits 12:8 and the register number in bits 4:0. All other bits read as 0.
- R3: Writing index 3 while idle stores bits 15:0 and sends a write frame. The frame is 32 ones, `01`, `01`, PHY address, register number, `10`, then the 16 data bits MSB first. The output enable stays high for all 64 bits.
- R4: When command bit 0 goes from 0 to 1 while idle, a read frame starts with opcode `10`. The output enable drops for the last 18 bits, which are the turnaround and the data.
- R5: In a read frame, the input is sampled at each rising MDC edge of bits 48 to 63, MSB first. The 16-bit result appears at index 4 once busy clears, and it does not change while idle.
- R6: Status bit 0 is 1 for exactly 64 MDC periods from the cycle after the launching write. It falls while MDC is low.
- R7: Config bits 4:2 select the MDC period in system clocks. Codes 0 to 7 select 4, 6, 8, 10, 12, 16, 20 and 28. Each bit spends the first half of its period with MDC low.
- R8: MDC stays low when no frame is active. The data output and the output enable do not change while MDC is high.
- R9: While busy, writes to index 1 and index 3 are dropped. Their registers keep their old values and no new frame follows.
- R10: A read starts only on a 0-to-1 change of command bit 0. Writing 1 again while the bit is already 1 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low synchronous reset |
| reg_sel | input | 1 | register access select |
| reg_we | input | 1 | write strobe, qualified by reg_sel |
| reg_addr | input | 3 | register word index |
| reg_wdata | input | 16 | write data |
| reg_rdata | output | 16 | read data for reg_addr (combinational) |
| mdc | output | 1 | management clock |
| mdio_o | output | 1 | data line output value |
| mdio_oe | output | 1 | data line output enable |
| mdio_i | input | 1 | data line input value |

## Verification
The hardest situation to reach is a trigger that lands while a frame is running. This covers a write-data update, a command clear, and a repeated set of the read bit without clearing it first. The bench launches a read, then issues these writes within the first cycles of the frame. It reads the registers back and watches the line after the frame ends to confirm that nothing was launched. A behavioural PHY model drives distinct data patterns during turnaround and the data bits. Divider codes 0, 3 and 7 are used so that bit timing is compared at every clock for short and long MDC periods.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

    localparam int MDM_BUS_W   = 16;
    localparam int MDM_ADDR_W  = 5;
    localparam int MDM_DATA_W  = 16;
    localparam int MDM_FRAME_W = 64;
    localparam int MDM_CNT_W   = 4;
    localparam int MDM_CODE_W  = 3;

    typedef enum logic [2:0] {
        RG_CFG   = 3'd0,
        RG_CMD   = 3'd1,
        RG_ADDR  = 3'd2,
        RG_WDATA = 3'd3,
        RG_RDATA = 3'd4,
        RG_STAT  = 3'd5
    } mdm_reg_e;

    typedef struct packed {
        logic [MDM_CODE_W-1:0] code;
        logic                  cmd;
        logic [MDM_ADDR_W-1:0] phy;
        logic [MDM_ADDR_W-1:0] regn;
        logic [MDM_DATA_W-1:0] wd;
        logic [MDM_DATA_W-1:0] rd;
    } mdm_regs_t;

    // half of the MDC period, in system clocks, for a divider code
    function automatic logic [MDM_CNT_W-1:0] mdm_half(input logic [MDM_CODE_W-1:0] code);
        case (code)
            3'd0:    return MDM_CNT_W'(2);
            3'd1:    return MDM_CNT_W'(3);
            3'd2:    return MDM_CNT_W'(4);
            3'd3:    return MDM_CNT_W'(5);
            3'd4:    return MDM_CNT_W'(6);
            3'd5:    return MDM_CNT_W'(8);
            3'd6:    return MDM_CNT_W'(10);
            default: return MDM_CNT_W'(14);
        endcase
    endfunction

endpackage

// File: rtl/mdm_clkgen.sv
module mdm_clkgen
    import mdm_pkg::*;
#(
    parameter int CNT_W  = MDM_CNT_W,
    parameter int CODE_W = MDM_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              run_i,
    output logic              mdc_o,
    output logic              rise_o,
    output logic              fall_o
);

    typedef struct packed {
        logic [CNT_W-1:0] half;
        logic [CNT_W-1:0] cnt;
        logic             mdc;
    } clk_st_t;

    clk_st_t s_d, s_q;
    logic    wrap;

    always_comb begin
        s_d  = s_q;
        wrap = (s_q.cnt == s_q.half - 1'b1);
        if (start_i) begin
            s_d.half = mdm_half(code_i);
        end
        if (!run_i) begin
            s_d.cnt = '0;
            s_d.mdc = 1'b0;
        end else if (wrap) begin
            s_d.cnt = '0;
            s_d.mdc = !s_q.mdc;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        rise_o = run_i && wrap && !s_q.mdc;
        fall_o = run_i && wrap && s_q.mdc;
        mdc_o  = s_q.mdc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.half <= CNT_W'(2);
            s_q.cnt  <= '0;
            s_q.mdc  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    // R8: MDC is parked low whenever no frame runs
    p_mdc_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> !s_q.mdc);

endmodule

// File: rtl/mdm_frame.sv
module mdm_frame
    import mdm_pkg::*;
#(
    parameter int FRAME_W = MDM_FRAME_W,
    parameter int DATA_W  = MDM_DATA_W,
    parameter int ADDR_W  = MDM_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              rd_op_i,
    input  logic [ADDR_W-1:0] phy_i,
    input  logic [ADDR_W-1:0] reg_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              mdio_i,
    output logic              busy_o,
    output logic              mdio_o,
    output logic              mdio_oe_o,
    output logic              done_rd_o,
    output logic [DATA_W-1:0] cap_o
);

    localparam int PRE_W   = FRAME_W - 2 * ADDR_W - 6 - DATA_W;
    localparam int BIT_W   = $clog2(FRAME_W);
    localparam int RD_REL  = FRAME_W - DATA_W - 2;
    localparam int RD_DATA = FRAME_W - DATA_W;

    typedef struct packed {
        logic               busy;
        logic               rd_op;
        logic [BIT_W-1:0]   bit_cnt;
        logic [FRAME_W-1:0] shreg;
        logic [DATA_W-1:0]  cap;
    } frm_st_t;

    frm_st_t s_d, s_q;
    logic    last_bit;

    always_comb begin
        s_d      = s_q;
        last_bit = (s_q.bit_cnt == BIT_W'(FRAME_W - 1));
        if (start_i) begin
            s_d.busy    = 1'b1;
            s_d.rd_op   = rd_op_i;
            s_d.bit_cnt = '0;
            s_d.cap     = '0;
            s_d.shreg   = {{PRE_W{1'b1}}, 2'b01,
                           (rd_op_i ? 2'b10 : 2'b01),
                           phy_i, reg_i,
                           (rd_op_i ? 2'b00 : 2'b10),
                           (rd_op_i ? {DATA_W{1'b0}} : wdata_i)};
        end else if (s_q.busy) begin
            if (rise_i && s_q.rd_op && (s_q.bit_cnt >= BIT_W'(RD_DATA))) begin
                s_d.cap = {s_q.cap[DATA_W-2:0], mdio_i};
            end
            if (fall_i) begin
                if (last_bit) begin
                    s_d.busy = 1'b0;
                end else begin
                    s_d.bit_cnt = s_q.bit_cnt + 1'b1;
                    s_d.shreg   = {s_q.shreg[FRAME_W-2:0], 1'b0};
                end
            end
        end
        busy_o    = s_q.busy;
        mdio_o    = s_q.busy && s_q.shreg[FRAME_W-1];
        mdio_oe_o = s_q.busy && (!s_q.rd_op || (s_q.bit_cnt < BIT_W'(RD_REL)));
        done_rd_o = s_q.busy && s_q.rd_op && fall_i && last_bit;
        cap_o     = s_q.cap;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R9: the register file never launches on top of a running frame
    p_start_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !s_q.busy);

    // R3: every frame begins at its first bit
    p_first_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.busy) |-> (s_q.bit_cnt == '0));

endmodule

// File: rtl/mdm_regs.sv
module mdm_regs
    import mdm_pkg::*;
#(
    parameter int BUS_W  = MDM_BUS_W,
    parameter int ADDR_W = MDM_ADDR_W,
    parameter int DATA_W = MDM_DATA_W,
    parameter int CODE_W = MDM_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              we_i,
    input  logic [2:0]        addr_i,
    input  logic [BUS_W-1:0]  wdata_i,
    output logic [BUS_W-1:0]  rdata_o,
    input  logic              busy_i,
    input  logic              done_rd_i,
    input  logic [DATA_W-1:0] cap_i,
    output logic              start_o,
    output logic              rd_op_o,
    output logic [CODE_W-1:0] code_o,
    output logic [ADDR_W-1:0] phy_o,
    output logic [ADDR_W-1:0] reg_o,
    output logic [DATA_W-1:0] wd_o
);

    localparam int CODE_LSB = 2;
    localparam int PHY_LSB  = 8;

    mdm_regs_t s_d, s_q;
    logic      wr;

    always_comb begin
        s_d     = s_q;
        wr      = sel_i && we_i;
        start_o = 1'b0;
        rd_op_o = 1'b0;
        if (wr) begin
            case (mdm_reg_e'(addr_i))
                RG_CFG: s_d.code = wdata_i[CODE_LSB +: CODE_W];
                RG_CMD: begin
                    if (!busy_i) begin
                        s_d.cmd = wdata_i[0];
                        if (wdata_i[0] && !s_q.cmd) begin
                            start_o = 1'b1;
                            rd_op_o = 1'b1;
                        end
                    end
                end
                RG_ADDR: begin
                    s_d.phy  = wdata_i[PHY_LSB +: ADDR_W];
                    s_d.regn = wdata_i[ADDR_W-1:0];
                end
                RG_WDATA: begin
                    if (!busy_i) begin
                        s_d.wd  = wdata_i[DATA_W-1:0];
                        start_o = 1'b1;
                    end
                end
                default: ;
            endcase
        end
        if (done_rd_i) begin
            s_d.rd = cap_i;
        end
        code_o = s_d.code;
        phy_o  = s_d.phy;
        reg_o  = s_d.regn;
        wd_o   = s_d.wd;

        rdata_o = '0;
        case (mdm_reg_e'(addr_i))
            RG_CFG:   rdata_o[CODE_LSB +: CODE_W] = s_q.code;
            RG_CMD:   rdata_o[0] = s_q.cmd;
            RG_ADDR: begin
                rdata_o[PHY_LSB +: ADDR_W] = s_q.phy;
                rdata_o[ADDR_W-1:0]        = s_q.regn;
            end
            RG_WDATA: rdata_o[DATA_W-1:0] = s_q.wd;
            RG_RDATA: rdata_o[DATA_W-1:0] = s_q.rd;
            RG_STAT:  rdata_o[0] = busy_i;
            default:  rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R9: command and write data hold while a frame runs
    p_cmd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(s_q.cmd));
    p_wd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(s_q.wd));

    // R5: read data only changes at the end of a frame
    p_rdata_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_i |=> $stable(s_q.rd));

endmodule

// File: rtl/mdm_master.sv
module mdm_master
    import mdm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_sel,
    input  logic                 reg_we,
    input  logic [2:0]           reg_addr,
    input  logic [MDM_BUS_W-1:0] reg_wdata,
    output logic [MDM_BUS_W-1:0] reg_rdata,
    output logic                 mdc,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    input  logic                 mdio_i
);

    logic                  start_w, rd_op_w, busy_w, done_rd_w, rise_w, fall_w;
    logic [MDM_CODE_W-1:0] code_w;
    logic [MDM_ADDR_W-1:0] phy_w, reg_w;
    logic [MDM_DATA_W-1:0] wd_w, cap_w;

    mdm_regs i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_i     (reg_sel),
        .we_i      (reg_we),
        .addr_i    (reg_addr),
        .wdata_i   (reg_wdata),
        .rdata_o   (reg_rdata),
        .busy_i    (busy_w),
        .done_rd_i (done_rd_w),
        .cap_i     (cap_w),
        .start_o   (start_w),
        .rd_op_o   (rd_op_w),
        .code_o    (code_w),
        .phy_o     (phy_w),
        .reg_o     (reg_w),
        .wd_o      (wd_w)
    );

    mdm_clkgen i_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_w),
        .code_i  (code_w),
        .run_i   (busy_w),
        .mdc_o   (mdc),
        .rise_o  (rise_w),
        .fall_o  (fall_w)
    );

    mdm_frame i_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_w),
        .rd_op_i   (rd_op_w),
        .phy_i     (phy_w),
        .reg_i     (reg_w),
        .wdata_i   (wd_w),
        .rise_i    (rise_w),
        .fall_i    (fall_w),
        .mdio_i    (mdio_i),
        .busy_o    (busy_w),
        .mdio_o    (mdio_o),
        .mdio_oe_o (mdio_oe),
        .done_rd_o (done_rd_w),
        .cap_o     (cap_w)
    );

    // R8: line output holds while MDC is high
    p_mdio_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R6: busy drops together with a low MDC
    p_busy_ends_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_w) |-> !mdc);

endmodule

// File: tb/test_mdm_master.sv
module test_mdm_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd5;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    always #4 clk = ~clk;

    mdm_master i_mdm_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    int n_chk = 0;
    int n_fail = 0;

    // behavioural reference state
    bit          m_active = 0;
    bit          m_rd = 0;
    int          m_k = 0;
    int          m_div = 4;
    logic [63:0] m_frame = '0;
    logic [15:0] m_phyval = '0;
    logic [2:0]  e_code = '0;
    logic        e_cmd = 1'b0;
    logic [4:0]  e_phy = '0;
    logic [4:0]  e_reg = '0;
    logic [15:0] e_wd = '0;
    logic [15:0] e_rd = '0;

    function automatic int div_of(input logic [2:0] c);
        case (c)
            3'd0: return 4;
            3'd1: return 6;
            3'd2: return 8;
            3'd3: return 10;
            3'd4: return 12;
            3'd5: return 16;
            3'd6: return 20;
            default: return 28;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic launch(input bit rd);
        m_active = 1;
        m_rd     = rd;
        m_k      = 0;
        m_div    = div_of(e_code);
        m_frame  = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), e_phy, e_reg,
                    (rd ? 2'b00 : 2'b10), (rd ? 16'h0000 : e_wd)};
    endtask

    // model advance on each rising edge
    always @(posedge clk) begin
        bit was;
        was = m_active;
        if (rst_n) begin
            if (m_active) begin
                m_k++;
                if (m_k == 64 * m_div) begin
                    m_active = 0;
                    if (m_rd) e_rd = m_phyval;
                end
            end
            if (reg_sel && reg_we) begin
                case (reg_addr)
                    3'd0: e_code = reg_wdata[4:2];
                    3'd1: if (!was) begin
                        if (reg_wdata[0] && !e_cmd) launch(1);
                        e_cmd = reg_wdata[0];
                    end
                    3'd2: begin
                        e_phy = reg_wdata[12:8];
                        e_reg = reg_wdata[4:0];
                    end
                    3'd3: if (!was) begin
                        e_wd = reg_wdata;
                        launch(0);
                    end
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison and PHY response
    always @(negedge clk) begin
        int   b;
        logic emdc, eoe, eo;
        string tag;
        #1;
        if (rst_n) begin
            b    = m_active ? m_k / m_div : 0;
            emdc = m_active && ((m_k % m_div) >= m_div / 2);
            eoe  = m_active && (!m_rd || b < 46);
            eo   = eoe ? m_frame[63 - b] : 1'b0;
            if (!m_active)      tag = "R8 idle line";
            else if (m_div != 4) tag = "R7 divided trace";
            else if (m_rd)       tag = "R4 read trace";
            else                 tag = "R3 write trace";
            check((mdc == emdc) && (mdio_oe == eoe) && (!eoe || mdio_o == eo), tag,
                  {29'd0, mdc, mdio_oe, mdio_o}, {29'd0, emdc, eoe, eo});
            if (reg_addr == 3'd5 && !reg_sel)
                check(reg_rdata[0] == m_active, "R6 busy flag",
                      {31'd0, reg_rdata[0]}, {31'd0, m_active});
            if (m_active && m_rd)
                mdio_i = (b >= 48) ? m_phyval[63 - b] : ((b == 47) ? 1'b0 : 1'b1);
            else
                mdio_i = 1'b1;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_sel = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_sel = 0; reg_we = 0; reg_addr = 3'd5;
    endtask

    task automatic rdchk(input logic [2:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #2;
        check(reg_rdata == exp, tag, {16'd0, reg_rdata}, {16'd0, exp});
        reg_addr = 3'd5;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        reg_addr = 3'd5;
        #2;
        while (reg_rdata[0]) begin
            n++;
            @(negedge clk);
            #2;
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        for (int a = 0; a < 6; a++) rdchk(a[2:0], 16'h0000, "R1 reset register");
        check(!mdc && !mdio_oe, "R1 reset line", {30'd0, mdc, mdio_oe}, 32'd0);

        // R2 address field placement
        wr(3'd2, 16'hE5F3);
        rdchk(3'd2, 16'h0513, "R2 address fields");
        wr(3'd0, 16'h0000);
        rdchk(3'd0, 16'h0000, "R2 config readback");

        // R3 write frame, R6 busy length
        wr(3'd3, 16'hA5C3);
        wait_idle(n);
        check(n == 256, "R6 busy length div4", n, 256);
        rdchk(3'd3, 16'hA5C3, "R3 write data stored");

        // R4/R5 read frame
        m_phyval = 16'h3C96;
        wr(3'd1, 16'h0001);
        wait_idle(n);
        check(n == 256, "R6 busy length read", n, 256);
        rdchk(3'd4, 16'h3C96, "R5 read data");
        rdchk(3'd1, 16'h0001, "R10 command bit kept");

        // R10 no relaunch while bit stays 1
        wr(3'd1, 16'h0001);
        repeat (3) @(negedge clk);
        rdchk(3'd5, 16'h0000, "R10 no relaunch");
        wr(3'd1, 16'h0000);
        m_phyval = 16'h8001;
        wr(3'd1, 16'h0001);
        rdchk(3'd5, 16'h0001, "R10 relaunch after clear");

        // R9 triggers dropped while busy
        wr(3'd3, 16'h1234);
        rdchk(3'd3, 16'hA5C3, "R9 write data dropped");
        wr(3'd1, 16'h0000);
        rdchk(3'd1, 16'h0001, "R9 command write dropped");
        wait_idle(n);
        rdchk(3'd4, 16'h8001, "R5 second read data");
        repeat (4) @(negedge clk);
        rdchk(3'd5, 16'h0000, "R9 no frame from dropped write");
        wr(3'd1, 16'h0000);
        rdchk(3'd1, 16'h0000, "R10 command cleared");

        // R7 divider code 7 write
        wr(3'd0, 16'h001C);
        rdchk(3'd0, 16'h001C, "R7 code field");
        wr(3'd2, 16'h1F00);
        wr(3'd3, 16'h0001);
        wait_idle(n);
        check(n == 64 * 28, "R7 busy length div28", n, 64 * 28);

        // R7 divider code 3 read
        wr(3'd0, 16'h000C);
        wr(3'd2, 16'h0A15);
        m_phyval = 16'h5A0F;
        wr(3'd1, 16'h0001);
        wait_idle(n);
        check(n == 640, "R7 busy length div10", n, 640);
        rdchk(3'd4, 16'h5A0F, "R5 read data div10");
        wr(3'd1, 16'h0000);
        repeat (4) @(negedge clk);
        summary();
    end

endmodule